// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a 1 KB direct-mapped cache placed between a processor word port and a slower memory port. A line holds 32 bytes (eight 32-bit words), so there are 32 lines. Each line has a valid flag and a stored tag. Read hits return the word in the cycle of the request. A read miss fetches the whole line from memory, one word per memory handshake, and then returns the requested word.

Every processor write is queued in a four-entry first-in first-out write buffer, and the memory port empties that buffer in order. A write that hits a valid line also updates the cached word in the same cycle as the enqueue. A write that misses leaves the cache untouched, so no line is allocated on a write. The processor stalls on a write only while the buffer is full. A read miss first waits until the buffer is empty, so that a refill never fetches memory that is older than a queued write.

The controller has three states. `ST_IDLE` serves hits and writes. A read miss moves it to `ST_WAIT_DRAIN`. When the buffer is empty it goes on to `ST_REFILL` and invalidates the target line on that transition. `ST_REFILL` returns to `ST_IDLE` on the acknowledge of the eighth word, which also sets the line valid. Back in `ST_IDLE`, the held request now hits and completes.

Top module: `dmc_wt_cache`

## Requirements
- R1: A synchronous reset clears every valid flag and empties the write buffer. After reset `mem_req` is 0 with no processor traffic, and the first read of any address is a miss.
- R2: Address bits 9:5 select the line, bits 31:10 form the tag and bits 4:2 select the word within the line. Bits 1:0 are ignored.
- R3: A read that hits raises `cpu_ready` in the cycle the request is presented, returns the stored word on `cpu_rdata`, and starts no memory read.
- R4: A read miss issues no memory read until the write buffer is empty. It then issues exactly eight read requests, at the line base address plus 0, 4, …, 28 in ascending order, and returns the requested word.
- R5: Every accepted write is sent to memory as a write request, and memory receives the writes in the order the processor issued them.
- R6: A write that hits updates the cached word, so a following read hit returns the new data without a memory read.
- R7: A write that misses allocates no line, so a later read of that address is a miss that refills from memory.
- R8: With four writes pending, a further write sees `cpu_ready` low until an entry has drained. The stalled write is then accepted and is not lost.
- R9: Two addresses with the same line index and different tags evict each other.
- R10: Once `mem_req` is raised, it and `mem_addr`/`mem_wdata` stay constant until the cycle in which `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is 1 for a read |
| cpu_ready | output | 1 | Request completes at the next rising edge |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write (buffer drain), 0 = read (refill) |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge completing the request |

## Verification
For read hits and for writes with buffer space, `cpu_ready` is combinational and is due in the request cycle itself. The bench therefore samples it 1 ns after driving the request, before the next edge, and checks that no extra cycle was counted. Read misses and stalled writes take a variable number of cycles, set by the memory model's latency and the buffer depth. For these the bench waits at each falling edge for `cpu_ready`, then checks the returned word and the logged memory traffic. Memory-side results such as drained writes and refill order are checked only once `mem_req` has gone low, from a log the memory model fills on every acknowledge.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_DRAIN = 2'd1,
        ST_REFILL     = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/dmc_wbuf.sv
module dmc_wbuf #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push |-> !full);  // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);  // R5
    AST_FILL_LEVEL:   assert property (@(posedge clk) disable iff (rst)
                          (push && !pop) |=> !empty);                                   // R5

endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
    parameter int DW     = 32,
    parameter int NLINES = 32,
    parameter int WPL    = 8,
    parameter int TAG_W  = 22,
    parameter int IDX_W  = 5,
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [WSEL_W-1:0] lk_wsel,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic [DW-1:0]     rd_data,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              fill_start,
    input  logic              fill_en,
    input  logic [WSEL_W-1:0] fill_wsel,
    input  logic [DW-1:0]     fill_data,
    input  logic              fill_done
);
    logic [NLINES-1:0] valid_q;
    logic [TAG_W-1:0]  tag_q  [NLINES];
    logic [DW-1:0]     data_q [NLINES][WPL];

    assign hit     = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign rd_data = data_q[lk_idx][lk_wsel];

    always_ff @(posedge clk) begin
        if (rst)             valid_q <= '0;
        else if (fill_start) valid_q[lk_idx] <= 1'b0;
        else if (fill_done)  valid_q[lk_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_done) tag_q[lk_idx] <= lk_tag;
    end

    always_ff @(posedge clk) begin
        if (fill_en)    data_q[lk_idx][fill_wsel] <= fill_data;
        else if (wr_en) data_q[lk_idx][lk_wsel]   <= wr_data;
    end

    AST_WRITE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
                             wr_en |-> hit);                                 // R7
    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
                             fill_done |=> hit);                             // R4

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int WPL    = 8,
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              hit,
    input  logic              wb_empty,
    input  logic              wb_full,
    input  logic              mem_ack,
    output logic              cpu_ready,
    output logic              wb_push,
    output logic              cache_wr,
    output logic              fill_start,
    output logic              fill_wr,
    output logic              fill_done,
    output logic              refill_active,
    output logic [WSEL_W-1:0] fill_wsel
);
    ctrl_state_e state, state_nx;
    logic        last_word;

    assign last_word = (fill_wsel == WSEL_W'(WPL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            fill_wsel <= '0;
        end else begin
            state <= state_nx;
            if (fill_start)   fill_wsel <= '0;
            else if (fill_wr) fill_wsel <= fill_wsel + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (cpu_req && !cpu_we && !hit) state_nx = ST_WAIT_DRAIN;
            ST_WAIT_DRAIN: if (wb_empty)                   state_nx = ST_REFILL;
            ST_REFILL:     if (mem_ack && last_word)       state_nx = ST_IDLE;
            default:                                       state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready     = 1'b0;
        wb_push       = 1'b0;
        cache_wr      = 1'b0;
        fill_start    = 1'b0;
        fill_wr       = 1'b0;
        fill_done     = 1'b0;
        refill_active = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req && cpu_we) begin
                    cpu_ready = !wb_full;
                    wb_push   = !wb_full;
                    cache_wr  = !wb_full && hit;
                end else if (cpu_req) begin
                    cpu_ready = hit;
                end
            end
            ST_WAIT_DRAIN: fill_start = wb_empty;
            ST_REFILL: begin
                refill_active = 1'b1;
                fill_wr       = mem_ack;
                fill_done     = mem_ack && last_word;
            end
            default: ;
        endcase
    end

    AST_REFILL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
                                (state == ST_REFILL) |-> wb_empty);               // R4
    AST_READ_ON_HIT:        assert property (@(posedge clk) disable iff (rst)
                                (cpu_ready && !cpu_we) |-> hit);                  // R3
    AST_STALL_WHEN_FULL:    assert property (@(posedge clk) disable iff (rst)
                                (cpu_req && cpu_we && wb_full) |-> !cpu_ready);   // R8
    AST_MISS_LEAVES_IDLE:   assert property (@(posedge clk) disable iff (rst)
                                (state == ST_IDLE && cpu_req && !cpu_we && !hit)
                                |=> (state == ST_WAIT_DRAIN));                    // R4

endmodule

// File: rtl/dmc_wt_cache.sv
module dmc_wt_cache #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int NLINES     = 32,
    parameter int WB_DEPTH   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);
    localparam int BYTE_W = $clog2(DW / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WPL    = LINE_BYTES / (DW / 8);
    localparam int WSEL_W = OFF_W - BYTE_W;
    localparam int IDX_W  = $clog2(NLINES);
    localparam int TAG_W  = AW - IDX_W - OFF_W;

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_wsel;

    assign a_tag  = cpu_addr[AW-1 -: TAG_W];
    assign a_idx  = cpu_addr[OFF_W +: IDX_W];
    assign a_wsel = cpu_addr[BYTE_W +: WSEL_W];

    logic              hit, wb_push, wb_pop, wb_empty, wb_full, cache_wr;
    logic              fill_start, fill_wr, fill_done, refill_active;
    logic [WSEL_W-1:0] fill_wsel;
    logic [AW-1:0]     wb_head_addr;
    logic [DW-1:0]     wb_head_data;

    dmc_ctrl #(.WPL(WPL), .WSEL_W(WSEL_W)) u_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .hit(hit),
        .wb_empty(wb_empty), .wb_full(wb_full), .mem_ack(mem_ack),
        .cpu_ready(cpu_ready), .wb_push(wb_push), .cache_wr(cache_wr),
        .fill_start(fill_start), .fill_wr(fill_wr), .fill_done(fill_done),
        .refill_active(refill_active), .fill_wsel(fill_wsel)
    );

    dmc_store #(.DW(DW), .NLINES(NLINES), .WPL(WPL), .TAG_W(TAG_W),
                .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_store (
        .clk(clk), .rst(rst), .lk_idx(a_idx), .lk_wsel(a_wsel), .lk_tag(a_tag),
        .hit(hit), .rd_data(cpu_rdata), .wr_en(cache_wr), .wr_data(cpu_wdata),
        .fill_start(fill_start), .fill_en(fill_wr), .fill_wsel(fill_wsel),
        .fill_data(mem_rdata), .fill_done(fill_done)
    );

    dmc_wbuf #(.AW(AW), .DW(DW), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk(clk), .rst(rst), .push(wb_push),
        .push_addr({cpu_addr[AW-1:BYTE_W], {BYTE_W{1'b0}}}),
        .push_data(cpu_wdata), .pop(wb_pop), .head_addr(wb_head_addr),
        .head_data(wb_head_data), .empty(wb_empty), .full(wb_full)
    );

    assign wb_pop    = mem_ack && !refill_active;
    assign mem_req   = refill_active || !wb_empty;
    assign mem_we    = !refill_active;
    assign mem_addr  = refill_active ? {a_tag, a_idx, fill_wsel, {BYTE_W{1'b0}}} : wb_head_addr;
    assign mem_wdata = wb_head_data;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
                      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                                 && $stable(mem_we)));          // R10
    AST_MEM_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
                      (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));  // R10

endmodule

// File: tb/dmc_wt_cache_bench.sv
module dmc_wt_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int MWORDS     = 4096;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int checks = 0, failures = 0, cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dmc_wt_cache u_dmc_wt_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    // behavioural memory with logs
    logic [31:0] mem    [MWORDS];
    logic [31:0] shadow [MWORDS];
    logic [31:0] rd_log [512];
    int          rd_wsnap [512];
    logic [31:0] wr_alog [512];
    logic [31:0] wr_dlog [512];
    int rd_cnt = 0, wr_cnt = 0, m_cnt = 0, hold_err = 0;
    logic        m_ack = 1'b0, hold_prev = 1'b0;
    logic [31:0] m_rdata = '0, prev_addr = '0;
    assign mem_ack   = m_ack;
    assign mem_rdata = m_rdata;

    function automatic logic [31:0] init_word(input int i);
        return 32'hC0DE_0000 ^ (i * 32'h0001_0101);
    endfunction

    initial begin
        for (int i = 0; i < MWORDS; i++) begin
            mem[i]    = init_word(i);
            shadow[i] = init_word(i);
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_ack <= 1'b0; m_cnt <= 0; hold_prev <= 1'b0;
        end else if (m_ack) begin
            m_ack <= 1'b0; m_cnt <= 0; hold_prev <= 1'b0;
        end else if (mem_req) begin
            if (hold_prev && mem_addr != prev_addr) hold_err <= hold_err + 1;
            hold_prev <= 1'b1;
            prev_addr <= mem_addr;
            if (m_cnt == LAT) begin
                m_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    wr_alog[wr_cnt[8:0]] <= mem_addr;
                    wr_dlog[wr_cnt[8:0]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    m_rdata <= mem[mem_addr[13:2]];
                    rd_log[rd_cnt[8:0]]   <= mem_addr;
                    rd_wsnap[rd_cnt[8:0]] <= wr_cnt;
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end else begin
            hold_prev <= 1'b0;
        end
    end

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        wait (cycles >= WATCHDOG);
        failures++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cycles, WATCHDOG);
        report();
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        cyc = 0;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata;
        if (we) shadow[addr[13:2]] = wd;
        @(posedge clk);
        #1 cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_drain;
        @(negedge clk); @(negedge clk);
        while (mem_req) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(mem_req == 1'b0, "R1 mem_req idle after reset", {31'd0, mem_req}, 32'd0);
        check(cpu_ready == 1'b0, "R1 no ready without request", {31'd0, cpu_ready}, 32'd0);
    endtask

    task automatic t_read_miss;
        logic [31:0] d; int c, r0;
        r0 = rd_cnt;
        access(1'b0, 32'h0000_0048, '0, d, c);
        check(rd_cnt - r0 == 8, "R1 first read after reset misses", rd_cnt - r0, 8);
        check(d == init_word(18), "R4 miss returns requested word", d, init_word(18));
        for (int k = 0; k < 8; k++)
            check(rd_log[r0 + k] == 32'h40 + 4 * k, "R4 refill order", rd_log[r0 + k], 32'h40 + 4 * k);
    endtask

    task automatic t_read_hit;
        logic [31:0] d; int c, r0;
        r0 = rd_cnt;
        access(1'b0, 32'h0000_0054, '0, d, c);
        check(c == 0, "R3 hit ready in request cycle", c, 0);
        check(d == init_word(21), "R3 hit data", d, init_word(21));
        access(1'b0, 32'h0000_0056, '0, d, c);
        check(d == init_word(21), "R2 byte bits ignored", d, init_word(21));
        check(rd_cnt == r0, "R3 hit makes no memory read", rd_cnt, r0);
    endtask

    task automatic t_write_hit;
        logic [31:0] d; int c, r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        access(1'b1, 32'h0000_004C, 32'h1234_5678, d, c);
        check(c == 0, "R5 write accepted at once", c, 0);
        access(1'b0, 32'h0000_004C, '0, d, c);
        check(d == 32'h1234_5678, "R6 write hit updates line", d, 32'h1234_5678);
        check(rd_cnt == r0, "R6 no memory read after write hit", rd_cnt, r0);
        wait_drain();
        check(wr_cnt == w0 + 1, "R5 one write reached memory", wr_cnt, w0 + 1);
        check(wr_alog[w0] == 32'h4C && wr_dlog[w0] == 32'h1234_5678, "R5 written address and data",
              wr_dlog[w0], 32'h1234_5678);
    endtask

    task automatic t_write_miss;
        logic [31:0] d; int c, r0;
        access(1'b1, 32'h0000_0200, 32'hDEAD_BEEF, d, c);
        wait_drain();
        r0 = rd_cnt;
        access(1'b0, 32'h0000_0200, '0, d, c);
        check(rd_cnt - r0 == 8, "R7 write miss not allocated", rd_cnt - r0, 8);
        check(d == 32'hDEAD_BEEF, "R7 refill sees written data", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_full_stall;
        logic [31:0] d; int c, w0;
        w0 = wr_cnt;
        for (int i = 0; i < 4; i++) begin
            access(1'b1, 32'h300 + 4 * i, 32'hA000_0000 + i, d, c);
            check(c == 0, "R8 write with space not stalled", c, 0);
        end
        access(1'b1, 32'h310, 32'hA000_0004, d, c);
        check(c > 0, "R8 fifth write stalls while full", c, 1);
        wait_drain();
        check(wr_cnt == w0 + 5, "R8 stalled write not lost", wr_cnt, w0 + 5);
        for (int i = 0; i < 5; i++)
            check(wr_alog[w0 + i] == 32'h300 + 4 * i && wr_dlog[w0 + i] == 32'hA000_0000 + i,
                  "R5 writes drained in order", wr_alog[w0 + i], 32'h300 + 4 * i);
    endtask

    task automatic t_read_after_writes;
        logic [31:0] d; int c, w0, r0;
        w0 = wr_cnt;
        access(1'b1, 32'h600, 32'h5555_0001, d, c);
        access(1'b1, 32'h604, 32'h5555_0002, d, c);
        r0 = rd_cnt;
        access(1'b0, 32'h800, '0, d, c);
        check(rd_wsnap[r0] == w0 + 2, "R4 refill waits for buffer empty", rd_wsnap[r0], w0 + 2);
        check(d == init_word(32'h200), "R4 refill data after drain", d, init_word(32'h200));
    endtask

    task automatic t_conflict;
        logic [31:0] d; int c, r0;
        access(1'b0, 32'h100, '0, d, c);
        r0 = rd_cnt;
        access(1'b0, 32'h500, '0, d, c);
        check(rd_cnt - r0 == 8, "R9 same index other tag misses", rd_cnt - r0, 8);
        check(d == init_word(32'h140), "R2 tag bit 10 separates blocks", d, init_word(32'h140));
        r0 = rd_cnt;
        access(1'b0, 32'h100, '0, d, c);
        check(rd_cnt - r0 == 8, "R9 evicted line misses again", rd_cnt - r0, 8);
        check(d == init_word(32'h40), "R9 data after re-fill", d, init_word(32'h40));
    endtask

    task automatic t_hold;
        check(hold_err == 0, "R10 request held until ack", hold_err, 0);
    endtask

    task automatic t_reset_again;
        logic [31:0] d; int c, r0;
        access(1'b1, 32'h700, 32'h7777_7777, d, c);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check(mem_req == 1'b0, "R1 reset empties write buffer", {31'd0, mem_req}, 32'd0);
        r0 = rd_cnt;
        access(1'b0, 32'h0000_0054, '0, d, c);
        check(rd_cnt - r0 == 8, "R1 reset clears valid flags", rd_cnt - r0, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_miss();
        t_read_hit();
        t_write_hit();
        t_write_miss();
        t_full_stall();
        t_read_after_writes();
        t_conflict();
        t_hold();
        t_reset_again();
        report();
        $finish;
    end

endmodule